// File: doc/BRIEF.md
# Capture/Compare Timer Array with Watchdog

The block is a set of capture/compare channels that share one free-running 16-bit time base. A tick multiplexer chooses what advances the time base. It can pick one of two internal prescalers of the system clock, the system clock itself, an overflow pulse from another timer, a synchronised external clock pin, or a prescaled external-oscillator enable. Each channel owns one 16-bit register and one pin. Each channel works in one of several modes. It can record the time of a pin edge, raise a flag when the time base reaches a programmed value, toggle its pin at that moment, generate 8-bit or 16-bit pulse-width modulation, or produce a square wave whose half-period is programmable.

The highest-numbered channel also serves as a watchdog. It leaves reset in that mode with the time base running, so a system that never touches the block is still protected. Software keeps the system alive by rewriting the channel's register before the time base reaches the programmed limit. The watchdog can only be switched off after the time base has been stopped.

Software reaches the block through a single-cycle write port and a combinational read port. Each channel raises an interrupt flag, and the watchdog drives a one-cycle reset request.

Top module: `ccu_array`

## Requirements
- R1: After reset the control word (address 0, bit 0 run, bits 3:1 tick source) reads 0x0001, channels 0..3 read mode 0, the last channel (address 12) reads mode 7, the flag word reads 0 and `wdt_rst_o` is low.
- R2: The time base advances by one on each selected tick while run is 1. It holds while run is 0. A write to address 1 loads it and overrides a tick in that cycle.
- R3: Tick source codes: 0 system clock / 12, 1 system clock / 4, 2 `t0_ovf_i` pulses, 3 external clock pin, 4 every system clock, 5 `xosc_i` enables / 8. Codes 6 and 7 give no ticks.
- R4: The external clock pin passes through a two-stage synchroniser, and only its rising edges produce a tick, one tick per edge.
- R5: In capture mode (mode field bits 2:0 = 1; bit 3 enables rising edges and bit 4 falling edges of the synchronised pin), a selected edge copies the time base into the channel register (address 16+n) and sets the channel flag. Edges that are not selected change nothing.
- R6: Mode 2 (software timer) sets the flag when the time base steps onto the register value, and leaves the pin undriven. Mode 3 (high-speed output) does the same and also toggles the driven pin.
- R7: Mode 4 (8-bit PWM) drives the pin low while the time base's low byte is below the register's low byte and high otherwise. The low byte reloads from the high byte on each low-byte overflow.
- R8: Mode 5 (16-bit PWM) drives the pin high exactly when the full time base is greater than or equal to the full register.
- R9: Mode 6 (frequency output) toggles the pin each time the time base's low byte steps onto the register's low byte, and then adds the register's high byte to the low byte. The pin toggles every H ticks, where H is the high byte.
- R10: In mode 7 on the last channel, a register write stores the written low byte L and sets the high byte to (time-base high byte + L). `wdt_rst_o` pulses for exactly one cycle when the time base steps onto {high byte, 0x00}.
- R11: A write that moves the last channel out of mode 7 is ignored while run is 1, and it is accepted while run is 0.
- R12: The flag word (address 2, bit n = channel n) clears only the bits written as 1. A hardware set takes priority over a clear in the same cycle.
- R13: Mode words sit at addresses 8+n and registers at 16+n. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data (combinational) |
| t0_ovf_i | input | 1 | Overflow pulse from another timer |
| eci_i | input | 1 | Asynchronous external clock pin |
| xosc_i | input | 1 | External oscillator enable pulse |
| cex_i | input | N_CH | Channel pins, input side |
| cex_o | output | N_CH | Channel pins, output value |
| cex_oe | output | N_CH | Channel pins, output enable |
| irq_o | output | N_CH | Per-channel interrupt flags |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The checker covers the time-base stepping rules on every cycle: at most one step per cycle, and no movement while stopped. It also covers the one-cycle width of the watchdog pulse, the lock that keeps the watchdog enabled while the time base runs, and the rule that a software-timer flag rises only with the time base sitting on the channel register. The bench scenarios are needed for the rest. Tick rates for each source, the single tick per external rising edge, PWM duty across a sweep of compare values and the square-wave period can only be shown by observing many cycles. The same holds for capture edge selection and for the watchdog staying quiet while it is serviced and firing once when it is not.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

   typedef enum logic [2:0] {
      CM_OFF   = 3'd0,
      CM_CAPT  = 3'd1,
      CM_SWT   = 3'd2,
      CM_HSO   = 3'd3,
      CM_PWM8  = 3'd4,
      CM_PWM16 = 3'd5,
      CM_FREQ  = 3'd6,
      CM_WDOG  = 3'd7
   } ccu_mode_e;

   localparam logic [2:0] SRC_SLOW = 3'd0;
   localparam logic [2:0] SRC_FAST = 3'd1;
   localparam logic [2:0] SRC_T0   = 3'd2;
   localparam logic [2:0] SRC_PIN  = 3'd3;
   localparam logic [2:0] SRC_SYS  = 3'd4;
   localparam logic [2:0] SRC_XOSC = 3'd5;

endpackage

// File: rtl/ccu_prescale.sv
module ccu_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic pulse
);
   localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("ccu_prescale: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      end
   end

   assign pulse = en && (cnt_q == LAST);
endmodule

// File: rtl/ccu_tick_mux.sv
module ccu_tick_mux import ccu_pkg::*; #(
   parameter int DIV_SLOW = 12,
   parameter int DIV_FAST = 4,
   parameter int DIV_XOSC = 8,
   parameter int SYNC_N   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       t0_ovf,
   input  logic       eci,
   input  logic       xosc_en,
   output logic       tick
);
   if (SYNC_N < 2) begin : g_bad_sync
      $error("ccu_tick_mux: SYNC_N must be at least 2");
   end

   logic slow_p, fast_p, xosc_p;
   logic [SYNC_N-1:0] eci_sy;
   logic eci_d;
   logic eci_tick;

   ccu_prescale #(.DIV(DIV_SLOW)) u_pre_slow (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .pulse(slow_p));
   ccu_prescale #(.DIV(DIV_FAST)) u_pre_fast (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .pulse(fast_p));
   ccu_prescale #(.DIV(DIV_XOSC)) u_pre_xosc (
      .clk(clk), .rst_n(rst_n), .en(xosc_en), .pulse(xosc_p));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eci_sy <= '0;
         eci_d  <= 1'b0;
      end else begin
         eci_sy <= {eci_sy[SYNC_N-2:0], eci};
         eci_d  <= eci_sy[SYNC_N-1];
      end
   end

   assign eci_tick = eci_sy[SYNC_N-1] & ~eci_d;

   always_comb begin
      case (sel)
         SRC_SLOW: tick = slow_p;
         SRC_FAST: tick = fast_p;
         SRC_T0:   tick = t0_ovf;
         SRC_PIN:  tick = eci_tick;
         SRC_SYS:  tick = 1'b1;
         SRC_XOSC: tick = xosc_p;
         default:  tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/ccu_chan.sv
module ccu_chan import ccu_pkg::*; #(
   parameter int             CNT_W    = 16,
   parameter bit             HAS_WDOG = 1'b0,
   parameter int             SYNC_N   = 2,
   parameter logic [CNT_W-1:0] CMP_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [CNT_W-1:0] cnt,
   input  ccu_mode_e        mode,
   input  logic             rise_en,
   input  logic             fall_en,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             cex_in,
   output logic [CNT_W-1:0] cmp_q,
   output logic             hit,
   output logic             cex_o,
   output logic             cex_oe,
   output logic             wdt_o
);
   localparam int HW = CNT_W / 2;

   logic [CNT_W-1:0]  nxt;
   logic [SYNC_N-1:0] pin_sy;
   logic              pin_d;
   logic              pin_rise, pin_fall, cap_ev;
   logic              wd_mode;
   logic              full_hit, lo_hit, lo_wrap, all_wrap;
   logic              tog_q, wdt_q;

   assign nxt = cnt + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_sy <= '0;
         pin_d  <= 1'b0;
      end else begin
         pin_sy <= {pin_sy[SYNC_N-2:0], cex_in};
         pin_d  <= pin_sy[SYNC_N-1];
      end
   end

   assign pin_rise = pin_sy[SYNC_N-1] & ~pin_d;
   assign pin_fall = ~pin_sy[SYNC_N-1] & pin_d;
   assign cap_ev   = (pin_rise & rise_en) | (pin_fall & fall_en);

   assign wd_mode  = HAS_WDOG && (mode == CM_WDOG);
   assign full_hit = adv && (nxt == cmp_q);
   assign lo_hit   = adv && (nxt[HW-1:0] == cmp_q[HW-1:0]);
   assign lo_wrap  = adv && (cnt[HW-1:0] == {HW{1'b1}});
   assign all_wrap = adv && (cnt == {CNT_W{1'b1}});

   always_comb begin
      case (mode)
         CM_CAPT:         hit = cap_ev;
         CM_SWT, CM_HSO:  hit = full_hit;
         CM_PWM8:         hit = lo_wrap;
         CM_PWM16:        hit = all_wrap;
         CM_FREQ:         hit = lo_hit;
         default:         hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= CMP_RST;
      end else if (cmp_wr) begin
         if (wd_mode) begin
            cmp_q <= {cnt[CNT_W-1:HW] + cmp_wdata[HW-1:0], cmp_wdata[HW-1:0]};
         end else begin
            cmp_q <= cmp_wdata;
         end
      end else begin
         case (mode)
            CM_CAPT: if (cap_ev) cmp_q <= cnt;
            CM_PWM8: if (lo_wrap) cmp_q[HW-1:0] <= cmp_q[CNT_W-1:HW];
            CM_FREQ: if (lo_hit) cmp_q[HW-1:0] <= cmp_q[HW-1:0] + cmp_q[CNT_W-1:HW];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if ((mode == CM_HSO && full_hit) || (mode == CM_FREQ && lo_hit)) begin
         tog_q <= ~tog_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wdt_q <= 1'b0;
      end else begin
         wdt_q <= wd_mode && adv && (nxt == {cmp_q[CNT_W-1:HW], {HW{1'b0}}});
      end
   end

   always_comb begin
      case (mode)
         CM_HSO, CM_FREQ: begin cex_o = tog_q;                               cex_oe = 1'b1; end
         CM_PWM8:         begin cex_o = !(cnt[HW-1:0] < cmp_q[HW-1:0]);      cex_oe = 1'b1; end
         CM_PWM16:        begin cex_o = (cnt >= cmp_q);                       cex_oe = 1'b1; end
         default:         begin cex_o = 1'b0;                                 cex_oe = 1'b0; end
      endcase
   end

   assign wdt_o = wdt_q;
endmodule

// File: rtl/ccu_array.sv
module ccu_array import ccu_pkg::*; #(
   parameter int N_CH     = 5,
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 5,
   parameter int DIV_SLOW = 12,
   parameter int DIV_FAST = 4,
   parameter int DIV_XOSC = 8,
   parameter int SYNC_N   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              t0_ovf_i,
   input  logic              eci_i,
   input  logic              xosc_i,
   input  logic [N_CH-1:0]   cex_i,
   output logic [N_CH-1:0]   cex_o,
   output logic [N_CH-1:0]   cex_oe,
   output logic [N_CH-1:0]   irq_o,
   output logic              wdt_rst_o
);
   localparam int WD_CH     = N_CH - 1;
   localparam int MODE_BASE = 8;
   localparam int CMP_BASE  = 16;

   if (N_CH < 1 || N_CH > 8) begin : g_bad_nch
      $error("ccu_array: N_CH must be 1..8");
   end
   if (CNT_W < 8 || (CNT_W % 2) != 0) begin : g_bad_cntw
      $error("ccu_array: CNT_W must be even and at least 8");
   end
   if (ADDR_W < 5) begin : g_bad_addrw
      $error("ccu_array: ADDR_W must be at least 5");
   end

   logic             run_q;
   logic [2:0]       sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [N_CH-1:0]  flag_q;
   ccu_mode_e        mode_q [N_CH];
   logic [N_CH-1:0]  rise_q, fall_q;

   logic             ctrl_wr, cnt_wr, flag_wr;
   logic             tick, adv;
   logic [N_CH-1:0]  mode_wr, cmp_wr, hit_v, wdt_v;
   logic [CNT_W-1:0] cmp_q [N_CH];
   logic [3*N_CH-1:0]     mode_flat;
   logic [CNT_W*N_CH-1:0] cmp_flat;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(0));
   assign cnt_wr  = wr_en && (wr_addr == ADDR_W'(1));
   assign flag_wr = wr_en && (wr_addr == ADDR_W'(2));

   ccu_tick_mux #(
      .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .DIV_XOSC(DIV_XOSC), .SYNC_N(SYNC_N)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .sel(sel_q), .t0_ovf(t0_ovf_i),
      .eci(eci_i), .xosc_en(xosc_i), .tick(tick));

   assign adv = tick && run_q && !cnt_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b1;
         sel_q <= SRC_SLOW;
      end else if (ctrl_wr) begin
         run_q <= wr_data[0];
         sel_q <= wr_data[3:1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= wr_data;
      end else if (adv) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      localparam bit IS_WD = (i == WD_CH);
      localparam logic [CNT_W-1:0] RST_V = IS_WD ? {CNT_W{1'b1}} : '0;

      if (IS_WD) begin : g_lock
         assign mode_wr[i] = wr_en && (wr_addr == ADDR_W'(MODE_BASE + i))
                             && !(run_q && mode_q[i] == CM_WDOG
                                  && wr_data[2:0] != 3'(CM_WDOG));
      end else begin : g_free
         assign mode_wr[i] = wr_en && (wr_addr == ADDR_W'(MODE_BASE + i));
      end
      assign cmp_wr[i] = wr_en && (wr_addr == ADDR_W'(CMP_BASE + i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q[i] <= IS_WD ? CM_WDOG : CM_OFF;
            rise_q[i] <= 1'b0;
            fall_q[i] <= 1'b0;
         end else if (mode_wr[i]) begin
            mode_q[i] <= ccu_mode_e'(wr_data[2:0]);
            rise_q[i] <= wr_data[3];
            fall_q[i] <= wr_data[4];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
         end else if (hit_v[i]) begin
            flag_q[i] <= 1'b1;
         end else if (flag_wr && wr_data[i]) begin
            flag_q[i] <= 1'b0;
         end
      end

      ccu_chan #(
         .CNT_W(CNT_W), .HAS_WDOG(IS_WD), .SYNC_N(SYNC_N), .CMP_RST(RST_V)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .adv(adv), .cnt(cnt_q), .mode(mode_q[i]),
         .rise_en(rise_q[i]), .fall_en(fall_q[i]), .cmp_wr(cmp_wr[i]),
         .cmp_wdata(wr_data), .cex_in(cex_i[i]), .cmp_q(cmp_q[i]),
         .hit(hit_v[i]), .cex_o(cex_o[i]), .cex_oe(cex_oe[i]), .wdt_o(wdt_v[i]));

      assign mode_flat[3*i +: 3]         = mode_q[i];
      assign cmp_flat[CNT_W*i +: CNT_W]  = cmp_q[i];
   end

   assign irq_o     = flag_q;
   assign wdt_rst_o = |wdt_v;

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(0)) rd_data[3:0] = {sel_q, run_q};
      if (rd_addr == ADDR_W'(1)) rd_data = cnt_q;
      if (rd_addr == ADDR_W'(2)) rd_data[N_CH-1:0] = flag_q;
      for (int i = 0; i < N_CH; i++) begin
         if (rd_addr == ADDR_W'(MODE_BASE + i)) rd_data[4:0] = {fall_q[i], rise_q[i], mode_q[i]};
         if (rd_addr == ADDR_W'(CMP_BASE + i))  rd_data = cmp_q[i];
      end
   end
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk #(
   parameter int N_CH  = 5,
   parameter int CNT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run_q,
   input logic                    cnt_wr,
   input logic [CNT_W-1:0]        cnt_q,
   input logic [N_CH-1:0]         flag_q,
   input logic [N_CH-1:0]         cmp_wr,
   input logic [3*N_CH-1:0]       mode_flat,
   input logic [CNT_W*N_CH-1:0]   cmp_flat,
   input logic                    wdt_rst_o
);
   localparam int WD_CH = N_CH - 1;

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cnt_wr) |-> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_q) && !$past(cnt_wr)) |-> (cnt_q == $past(cnt_q)));

   p_wdt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_o |=> !wdt_rst_o);

   p_wdog_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_q) && $past(mode_flat[3*WD_CH +: 3]) == 3'd7) |-> (mode_flat[3*WD_CH +: 3] == 3'd7));

   for (genvar i = 0; i < N_CH; i++) begin : g_swt
      p_swt_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(flag_q[i]) && mode_flat[3*i +: 3] == 3'd2 && $past(mode_flat[3*i +: 3]) == 3'd2
          && !$past(cmp_wr[i]) && !$past(cnt_wr))
         |-> (cnt_q == cmp_flat[CNT_W*i +: CNT_W]));
   end
endmodule

bind ccu_array ccu_array_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt_wr(cnt_wr), .cnt_q(cnt_q),
   .flag_q(flag_q), .cmp_wr(cmp_wr), .mode_flat(mode_flat), .cmp_flat(cmp_flat),
   .wdt_rst_o(wdt_rst_o));

// File: tb/ccu_array_tb.sv
`timescale 1ns/1ps
module ccu_array_tb;
   localparam int N_CH = 5, CNT_W = 16, ADDR_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [CNT_W-1:0] wr_data = '0, rd_data;
   logic t0_ovf = 1'b0, eci = 1'b0, xosc = 1'b0;
   logic [N_CH-1:0] cex_i = '0, cex_o, cex_oe, irq_o;
   logic wdt_rst_o;

   ccu_array u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .t0_ovf_i(t0_ovf), .eci_i(eci), .xosc_i(xosc),
      .cex_i(cex_i), .cex_o(cex_o), .cex_oe(cex_oe), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o));

   always #2.5 clk = ~clk;

   int nvec = 0, nfail = 0, cyc = 0, late_wdt = 0;
   bit done = 1'b0, wd_off = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (wd_off && wdt_rst_o) late_wdt <= late_wdt + 1;

   initial forever begin @(negedge clk); t0_ovf = (cyc % 3 == 0); xosc = (cyc % 2 == 0); end
   initial forever begin repeat (5) @(negedge clk); eci = ~eci; end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      rd_addr = ADDR_W'(a);
      #1 d = int'(rd_data);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      int v, pulses, width_bad;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, v);  chk(v == 1, "R1 control", v, 1);
      rd(12, v); chk(v == 7, "R1 last channel mode", v, 7);
      rd(8, v);  chk(v == 0, "R1 channel 0 mode", v, 0);
      rd(2, v);  chk(v == 0, "R1 flags", v, 0);
      chk(wdt_rst_o == 1'b0, "R1 wdt low", int'(wdt_rst_o), 0);
      // R13 unmapped
      rd(3, v);  chk(v == 0, "R13 unmapped 3", v, 0);
      rd(31, v); chk(v == 0, "R13 unmapped 31", v, 0);

      // R11 disable refused while running
      wr(12, 0);
      rd(12, v); chk(v == 7, "R11 locked while running", v, 7);

      // R10 serviced watchdog stays quiet
      wr(0, 9);
      pulses = 0;
      for (int k = 0; k < 10; k++) begin
         wr(20, 2);
         for (int c = 0; c < 200; c++) begin @(negedge clk); if (wdt_rst_o) pulses++; end
      end
      chk(pulses == 0, "R10 no reset while serviced", pulses, 0);
      pulses = 0; width_bad = 0;
      for (int c = 0; c < 1000; c++) begin
         @(negedge clk);
         if (wdt_rst_o) begin
            pulses++;
            @(negedge clk);
            if (wdt_rst_o) width_bad++;
         end
      end
      chk(pulses == 1, "R10 single expiry", pulses, 1);
      chk(width_bad == 0, "R10 one-cycle pulse", width_bad, 0);
      wr(0, 8);
      wr(1, 16'h3456);
      wr(20, 5);
      rd(20, v); chk(v == 16'h3905, "R10 reload arithmetic", v, 16'h3905);
      repeat (20) @(negedge clk);
      rd(1, v); chk(v == 16'h3456, "R2 hold while stopped", v, 16'h3456);
      // R11 disable accepted while stopped
      wr(12, 0);
      rd(12, v); chk(v == 0, "R11 disabled while stopped", v, 0);
      wd_off = 1'b1;

      // R3 / R4 tick sources
      for (int s = 0; s < 7; s++) begin
         int expv;
         case (s)
            0: expv = 20; 1: expv = 60; 2: expv = 80; 3: expv = 24;
            4: expv = 240; 5: expv = 15; default: expv = 0;
         endcase
         wr(0, s << 1);
         wr(1, 0);
         wr(0, (s << 1) | 1);
         repeat (240) @(negedge clk);
         wr(0, s << 1);
         rd(1, v);
         if (s == 3) chk(v >= expv - 2 && v <= expv + 2, "R4 one tick per rising pin edge", v, expv);
         else if (s == 6) chk(v == 0, "R3 unused code gives no ticks", v, 0);
         else chk(v >= expv - 2 && v <= expv + 2, "R3 tick rate", v, expv);
      end

      // R7 8-bit PWM on channel 0
      wr(8, 4);
      for (int h = 0; h < 5; h++) begin
         int hv, highs;
         case (h) 0: hv = 0; 1: hv = 1; 2: hv = 64; 3: hv = 128; default: hv = 255; endcase
         wr(0, 8);
         wr(16, (hv << 8) | 3);
         wr(0, 9);
         repeat (300) @(negedge clk);
         highs = 0;
         for (int c = 0; c < 256; c++) begin @(negedge clk); #1; if (cex_o[0]) highs++; end
         chk(highs == 256 - hv, "R7 PWM8 duty after reload", highs, 256 - hv);
      end
      chk(cex_oe[0] == 1'b1, "R7 PWM8 drives pin", int'(cex_oe[0]), 1);
      wr(0, 8);
      wr(8, 0);

      // R8 16-bit PWM on channel 1
      wr(9, 5);
      wr(17, 16'h1234);
      wr(1, 16'h1233); #1 chk(cex_o[1] == 1'b0, "R8 below compare", int'(cex_o[1]), 0);
      wr(1, 16'h1234); #1 chk(cex_o[1] == 1'b1, "R8 equal compare", int'(cex_o[1]), 1);
      wr(1, 16'hFFFF); #1 chk(cex_o[1] == 1'b1, "R8 top value", int'(cex_o[1]), 1);
      wr(1, 16'h0000); #1 chk(cex_o[1] == 1'b0, "R8 zero", int'(cex_o[1]), 0);

      // R5 capture on channel 1
      wr(9, 1 | 8);
      wr(2, 16'h1F);
      wr(1, 16'h0ABC);
      @(negedge clk); cex_i[1] = 1'b1;
      repeat (6) @(negedge clk);
      rd(17, v); chk(v == 16'h0ABC, "R5 rising capture", v, 16'h0ABC);
      rd(2, v);  chk(v == 2, "R5 capture flag", v, 2);
      wr(2, 2);
      wr(1, 16'h0BCD);
      @(negedge clk); cex_i[1] = 1'b0;
      repeat (6) @(negedge clk);
      rd(17, v); chk(v == 16'h0ABC, "R5 unselected edge ignored", v, 16'h0ABC);
      rd(2, v);  chk(v == 0, "R5 unselected edge no flag", v, 0);
      wr(9, 1 | 16);
      @(negedge clk); cex_i[1] = 1'b1;
      repeat (6) @(negedge clk);
      rd(17, v); chk(v == 16'h0ABC, "R5 rising ignored in falling mode", v, 16'h0ABC);
      @(negedge clk); cex_i[1] = 1'b0;
      repeat (6) @(negedge clk);
      rd(17, v); chk(v == 16'h0BCD, "R5 falling capture", v, 16'h0BCD);
      wr(9, 0);

      // R6 high-speed output on channel 2
      wr(10, 3);
      wr(18, 16'h0100);
      wr(1, 16'h00FB);
      wr(2, 16'h1F);
      wr(0, 9);
      repeat (12) @(negedge clk);
      wr(0, 8);
      rd(2, v); chk(v == 4, "R6 HSO flag", v, 4);
      chk(cex_o[2] == 1'b1 && cex_oe[2] == 1'b1, "R6 HSO pin toggled", int'({cex_oe[2], cex_o[2]}), 3);
      // R6 software timer on channel 3
      wr(11, 2);
      wr(19, 16'h0200);
      wr(1, 16'h01F0);
      wr(2, 16'h1F);
      wr(0, 9);
      repeat (30) @(negedge clk);
      wr(0, 8);
      rd(2, v); chk(v == 8, "R6 SWT flag only", v, 8);
      chk(cex_oe[3] == 1'b0, "R6 SWT pin undriven", int'(cex_oe[3]), 0);
      // R12 write-one-to-clear
      wr(2, 4);
      rd(2, v); chk(v == 8, "R12 zero bits keep flags", v, 8);
      wr(2, 8);
      rd(2, v); chk(v == 0, "R12 one bit clears", v, 0);
      wr(11, 0);

      // R9 frequency output on channel 2
      for (int h = 0; h < 4; h++) begin
         int hv, ntog, bad, last_t, prev;
         case (h) 0: hv = 1; 1: hv = 3; 2: hv = 10; default: hv = 37; endcase
         wr(0, 8);
         wr(10, 0);
         wr(1, 0);
         wr(18, (hv << 8) | 5);
         wr(10, 6);
         wr(0, 9);
         ntog = 0; bad = -1; last_t = 0;
         @(negedge clk); #1 prev = int'(cex_o[2]);
         for (int c = 0; c < 400 && ntog < 6; c++) begin
            @(negedge clk); #1;
            if (int'(cex_o[2]) != prev) begin
               prev = int'(cex_o[2]);
               if (ntog > 0 && bad < 0 && (c - last_t) != hv) bad = c - last_t;
               last_t = c;
               ntog++;
            end
         end
         wr(0, 8);
         chk(ntog == 6 && bad < 0, "R9 toggle interval", (bad < 0) ? hv : bad, hv);
      end

      chk(late_wdt == 0, "R11 no reset after disable", late_wdt, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule